// File: doc/BRIEF.md
# Reloadable Wake-Up Timer

This block is a 23-bit down-counting system timer that keeps running while the rest of the chip sleeps. It is built from a 7-bit prescaler below a 16-bit loadable section. Each load puts two software-written reload bytes into the upper 16 bits and all ones into the low 7 bits. When the count is exhausted, the block reloads itself and sets a sticky underflow flag. That flag drives a wake-up request and, when an interrupt enable is high, an interrupt request.

Software reaches the block through a small byte-wide register port. Address 0 is the control register. Addresses 1 and 2 are the upper and lower reload bytes. The whole design runs on one system clock. Two tick-enable inputs stand for the core clock and the crystal oscillator. The select field in the control register chooses between them. When the crystal is already clocking the core, the block always counts core ticks.

Top module: `wakeTimer`

## Requirements
- R1: A synchronous reset clears the control register, both reload registers and the counter, and holds `irq` and `wakeReq` low. All three registers read 0x00 afterwards.
- R2: Register map on `regAddr`:
  - 0 is control: bit 7 is the flag, bits 2:1 are the select field, bit 0 is enable, and the other bits read 0.
  - 1 is the upper reload byte.
  - 2 is the lower reload byte.
  - Written values read back on `regRdData`.
- R3: Writing enable from 0 to 1 loads {upper, lower, 7'h7F}. The flag is set on exactly the 128·(upper·256+lower+1)-th selected tick, and not one tick earlier.
- R4: On underflow the counter reloads the same concatenated value, so the flag recurs every 128·(reload+1) selected ticks.
- R5: While enable is 0 the counter stays at zero and ticks have no effect. Enabling again restarts a full period.
- R6: Select value 0 counts `coreTick`, and any nonzero select value counts `xtalTick`. The unselected tick input has no effect.
- R7: While `xtalIsCore` is 1, the block counts `coreTick` whatever the select field holds.
- R8: The flag is sticky. Writing control with bit 7 = 0 clears it, and writing bit 7 = 1 never sets it. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: `wakeReq` follows the flag, and `irq` is the flag gated by `irqEnable`.
- R10: A write to either reload byte changes nothing in the count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| coreTick | input | 1 | Core clock tick enable |
| xtalTick | input | 1 | Crystal oscillator tick enable |
| xtalIsCore | input | 1 | Crystal currently drives the core |
| irqEnable | input | 1 | Interrupt enable for the underflow flag |
| irq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wake-up request from power-down |

## Verification
The counter itself is not visible at the ports. A wrong count, a wrong load pattern or a wrong tick choice therefore shows only in the cycle where the flag rises. The bench counts selected ticks and checks the flag both one tick before the expected underflow and on it.

A corrupted prescaler or a dropped reload surfaces within one period, which is at most 128·(reload+1) ticks. An error in the upper byte position appears only with a nonzero upper byte, so one long-period case covers it.

// File: rtl/wakeTimerPkg.sv
package wakeTimerPkg;
  localparam int unsigned PRE_W  = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;

  // control register bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_SEL  = 1;
  localparam int unsigned BIT_FLAG = 7;

  typedef struct packed {
    logic clear;
    logic load;
    logic dec;
  } cntStb_t;
endpackage

// File: rtl/wakeTimerDatapath.sv
module wakeTimerDatapath
  import wakeTimerPkg::*;
#(
  parameter int unsigned PreW  = PRE_W,
  parameter int unsigned ByteW = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStb_t          stb,
  input  logic [ByteW-1:0] reloadHi,
  input  logic [ByteW-1:0] reloadLo,
  output logic             cntZero
);
  localparam int unsigned CntW = PreW + 2 * ByteW;

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] reloadVal;

  assign reloadVal = {reloadHi, reloadLo, {PreW{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= reloadVal;
    end else if (stb.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/wakeTimerCtrl.sv
module wakeTimerCtrl
  import wakeTimerPkg::*;
#(
  parameter int unsigned ByteW = BYTE_W,
  parameter int unsigned AddrW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [AddrW-1:0] regAddr,
  input  logic [ByteW-1:0] regWrData,
  output logic [ByteW-1:0] regRdData,
  input  logic             coreTick,
  input  logic             xtalTick,
  input  logic             xtalIsCore,
  input  logic             cntZero,
  output cntStb_t          stb,
  output logic [ByteW-1:0] reloadHi,
  output logic [ByteW-1:0] reloadLo,
  output logic             flag
);
  logic       enable;
  logic [1:0] clkSel;
  logic       ctrlWr;
  logic       enNext;
  logic       useCore;
  logic       selTick;
  logic       underflow;

  assign ctrlWr    = regWrEn && (regAddr == ADDR_CTRL);
  assign enNext    = ctrlWr ? regWrData[BIT_EN] : enable;
  assign useCore   = xtalIsCore || (clkSel == 2'b00);
  assign selTick   = useCore ? coreTick : xtalTick;
  assign underflow = enable && selTick && cntZero;

  always_comb begin
    stb.clear = !enNext;
    stb.load  = enNext && (!enable || underflow);
    stb.dec   = enNext && enable && selTick && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      clkSel   <= 2'b00;
      reloadHi <= '0;
      reloadLo <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL: begin
          enable <= regWrData[BIT_EN];
          clkSel <= regWrData[BIT_SEL +: 2];
        end
        ADDR_HI: reloadHi <= regWrData;
        ADDR_LO: reloadLo <= regWrData;
        default: ;
      endcase
    end
  end

  // set has priority over a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (underflow) begin
      flag <= 1'b1;
    end else if (ctrlWr && !regWrData[BIT_FLAG]) begin
      flag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[BIT_FLAG]      = flag;
        regRdData[BIT_SEL +: 2]  = clkSel;
        regRdData[BIT_EN]        = enable;
      end
      ADDR_HI: regRdData = reloadHi;
      ADDR_LO: regRdData = reloadLo;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/wakeTimer.sv
module wakeTimer
  import wakeTimerPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       coreTick,
  input  logic       xtalTick,
  input  logic       xtalIsCore,
  input  logic       irqEnable,
  output logic       irq,
  output logic       wakeReq
);
  cntStb_t          stb;
  logic             cntZero;
  logic [BYTE_W-1:0] reloadHi;
  logic [BYTE_W-1:0] reloadLo;
  logic             flag;

  wakeTimerCtrl #(.ByteW(BYTE_W), .AddrW(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .coreTick(coreTick), .xtalTick(xtalTick), .xtalIsCore(xtalIsCore),
    .cntZero(cntZero), .stb(stb),
    .reloadHi(reloadHi), .reloadLo(reloadLo), .flag(flag)
  );

  wakeTimerDatapath #(.PreW(PRE_W), .ByteW(BYTE_W)) uData (
    .clk(clk), .rst(rst), .stb(stb),
    .reloadHi(reloadHi), .reloadLo(reloadLo), .cntZero(cntZero)
  );

  assign wakeReq = flag;
  assign irq     = flag && irqEnable;
endmodule

// File: rtl/wakeTimerChecker.sv
module wakeTimerChecker (
  input logic       clk,
  input logic       rst,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic       coreTick,
  input logic       xtalTick,
  input logic       irqEnable,
  input logic       irq,
  input logic       wakeReq
);
  logic clrWr;
  logic anyTick;
  assign clrWr   = regWrEn && (regAddr == 2'd0) && !regWrData[7];
  assign anyTick = coreTick || xtalTick;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && !wakeReq)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wakeReq && !clrWr) |=> wakeReq); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clrWr && !anyTick) |=> !wakeReq); // R8

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(wakeReq) |-> $past(anyTick)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irqEnable |-> !irq); // R9
endmodule

bind wakeTimer wakeTimerChecker uChk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .coreTick(coreTick), .xtalTick(xtalTick), .irqEnable(irqEnable),
  .irq(irq), .wakeReq(wakeReq)
);

// File: tb/sim_wakeTimer.sv
module sim_wakeTimer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       coreTick = 1'b0;
  logic       xtalTick = 1'b0;
  logic       xtalIsCore = 1'b0;
  logic       irqEnable = 1'b1;
  logic       irq;
  logic       wakeReq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  wakeTimer u0 (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .coreTick(coreTick), .xtalTick(xtalTick), .xtalIsCore(xtalIsCore),
    .irqEnable(irqEnable), .irq(irq), .wakeReq(wakeReq)
  );

  // {hi, lo, sel, xtalIsCore, tickXtal, expected ticks}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'd0, 1'b0, 1'b0, 16'd128},
    {8'h00, 8'h01, 2'd1, 1'b0, 1'b1, 16'd256},
    {8'h00, 8'h02, 2'd2, 1'b0, 1'b1, 16'd384},
    {8'h00, 8'h00, 2'd3, 1'b0, 1'b1, 16'd128},
    {8'h00, 8'h01, 2'd1, 1'b1, 1'b0, 16'd256},
    {8'h00, 8'h00, 2'd2, 1'b1, 1'b0, 16'd128},
    {8'h01, 8'h00, 2'd0, 1'b0, 1'b0, 16'd32896}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ticks(input int n, input bit useXtal);
    if (n > 0) begin
      @(negedge clk);
      if (useXtal) xtalTick = 1'b1; else coreTick = 1'b1;
      repeat (n) @(negedge clk);
      xtalTick = 1'b0; coreTick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state R1
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 hi", v, 8'h00);
    rd(2'd2, v); chk("R1 lo", v, 8'h00);
    chk("R1 wake/irq", {6'd0, wakeReq, irq}, 8'h00);

    // register map R2, write-one does not set flag R8
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 hi", v, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 lo", v, 8'h3C);
    wr(2'd0, 8'hFE); rd(2'd0, v); chk("R2/R8 ctrl", v, 8'h06);
    wr(2'd0, 8'h00);

    // table walk R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [7:0] hi, lo;
      logic [1:0] sel;
      logic xc, useX;
      int exp;
      string tag;
      {hi, lo, sel, xc, useX} = VEC[i][35:16];
      exp = int'(VEC[i][15:0]);
      tag = xc ? "R7" : ((sel != 2'd0) ? "R6" : "R3");
      wr(2'd0, 8'h00);
      xtalIsCore = xc;
      wr(2'd1, hi); wr(2'd2, lo);
      wr(2'd0, {5'd0, sel, 1'b1});
      ticks(200, !useX);
      ticks(exp - 1, useX);
      chk(tag, {7'd0, wakeReq}, 8'h00);
      ticks(1, useX);
      chk(tag, {7'd0, wakeReq}, 8'h01);
      chk("R9 irq", {7'd0, irq}, 8'h01);
    end
    xtalIsCore = 1'b0;

    // periodic reload R4
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    ticks(128, 1'b0);
    chk("R4 first", {7'd0, wakeReq}, 8'h01);
    wr(2'd0, 8'h01);
    chk("R8 clear", {7'd0, wakeReq}, 8'h00);
    ticks(127, 1'b0);
    chk("R4 early", {7'd0, wakeReq}, 8'h00);
    ticks(1, 1'b0);
    chk("R4 second", {7'd0, wakeReq}, 8'h01);

    // set wins over clear R8
    wr(2'd0, 8'h01);
    ticks(127, 1'b0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h01; coreTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; coreTick = 1'b0;
    chk("R8 set wins", {7'd0, wakeReq}, 8'h01);

    // irq gating R9
    irqEnable = 1'b0;
    #1 chk("R9 masked", {6'd0, wakeReq, irq}, 8'h02);
    irqEnable = 1'b1;
    #1 chk("R9 unmasked", {6'd0, wakeReq, irq}, 8'h03);

    // reload write mid-count R10
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    ticks(50, 1'b0);
    wr(2'd2, 8'h01);
    ticks(77, 1'b0);
    chk("R10 early", {7'd0, wakeReq}, 8'h00);
    ticks(1, 1'b0);
    chk("R10 old period", {7'd0, wakeReq}, 8'h01);
    wr(2'd0, 8'h01);
    ticks(255, 1'b0);
    chk("R10 new early", {7'd0, wakeReq}, 8'h00);
    ticks(1, 1'b0);
    chk("R10 new period", {7'd0, wakeReq}, 8'h01);

    // disabled holds, restart R5
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    ticks(300, 1'b0);
    chk("R5 disabled", {7'd0, wakeReq}, 8'h00);
    wr(2'd0, 8'h01);
    ticks(100, 1'b0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    ticks(127, 1'b0);
    chk("R5 restart early", {7'd0, wakeReq}, 8'h00);
    ticks(1, 1'b0);
    chk("R5 restart", {7'd0, wakeReq}, 8'h01);

    // reset mid-operation R1
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 after reset", {6'd0, wakeReq, irq}, 8'h00);
    rd(2'd0, v); chk("R1 ctrl after", v, 8'h00);
    rd(2'd2, v); chk("R1 lo after", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule